// File: doc/BRIEF.md
# Busy-Handshake Memory Responder

This block is the memory-side responder for a small processor core. The core issues reads and writes on two independent request strobes, each one clock long. Each direction has its own busy flag, so a write in progress never holds back a read. A parameter sets a fixed number of wait states for both directions. Setting it to zero gives a responder that is never busy: the read word appears on the cycle after the request, and the write takes effect at that same edge.

Storage is an array of 32-bit words addressed by word index. Writes carry a per-bit enable mask, so any subset of bits can be updated while the other bits keep their contents. A request made while its own channel is busy breaks the protocol. Such a request is dropped, and it sets a sticky error flag that only reset clears.

The block also holds a level interrupt request. A raise strobe sets it, and it stays high until the core pulses the clear input.

Top module: `hs_mem_responder`

## Requirements
- R1: A write is accepted on a cycle where `wr_req` is 1 and `wr_busy` is 0. Address, data and mask are taken from that cycle only, and later changes to those inputs do not affect the write.
- R2: A read is accepted on a cycle where `rd_req` is 1 and `rd_busy` is 0. The read address is taken from that cycle only.
- R3: With WAIT greater than 0, the busy flag of a channel is high for exactly WAIT cycles after the edge that accepts its request, and it is low otherwise.
- R4: `rd_data` takes the addressed word at the edge where `rd_busy` falls, which is WAIT edges after the accepting edge. It holds that value until the next read completes.
- R5: With WAIT equal to 0, neither busy flag ever rises. Read data is visible right after the accepting edge, and a write is visible to a read accepted at the next edge.
- R6: For each bit position b, a write stores `wr_data[b]` when `wr_mask[b]` is 1 and keeps the stored bit when `wr_mask[b]` is 0.
- R7: A request on a channel whose busy flag is high sets `proto_err`. It is otherwise ignored: memory is not changed, busy is not extended, and `rd_data` is not changed.
- R8: `proto_err` stays 1 until reset.
- R9: A one-cycle `irq_raise` pulse sets `irq`, and `irq` stays 1 until a cycle with `irq_clear` 1. When raise and clear are both 1 in the same cycle, raise wins.
- R10: Reset (`rst_n` 0) clears both busy flags, `proto_err`, `irq` and `rd_data` to 0. It does not change the memory contents.
- R11: A read and a write issued in the same cycle are both accepted, and neither is flagged as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request strobe, one cycle |
| rd_addr | input | AW | Word address of the read |
| rd_busy | output | 1 | Read channel busy |
| rd_data | output | 32 | Last completed read word |
| wr_req | input | 1 | Write request strobe, one cycle |
| wr_addr | input | AW | Word address of the write |
| wr_data | input | 32 | Write word |
| wr_mask | input | 32 | Per-bit write enable |
| wr_busy | output | 1 | Write channel busy |
| irq_raise | input | 1 | Sets the interrupt request |
| irq_clear | input | 1 | Clears the interrupt request |
| irq | output | 1 | Level interrupt request |
| proto_err | output | 1 | Sticky flag for a request made while busy |

## Verification
The assertions check on every cycle that each busy window lasts exactly WAIT cycles, that a zero-wait build is never busy, and that a request made while busy raises the error flag, which then stays set. They also check that the interrupt level holds until it is cleared, and that read data changes only on a completion edge. The bench scenarios are what show the stored contents. These are full and masked writes over every address, dropped requests that leave memory and read data untouched, inputs that change after a request is accepted, and memory kept across a reset. A WAIT=2 and a WAIT=0 instance receive the same stimulus, so the two timings are compared edge by edge.

// File: rtl/hs_mem_pkg.sv
package hs_mem_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // Per-bit merge: mask 1 takes the new bit, mask 0 keeps the old bit.
  function automatic word_t merge_bits(word_t old_w, word_t new_w, word_t en);
    return (old_w & ~en) | (new_w & en);
  endfunction

  // Width of a down-counter that must hold the value w.
  function automatic int cnt_width(int w);
    return (w < 1) ? 1 : $clog2(w + 1);
  endfunction
endpackage

// File: rtl/hs_wait_chan.sv
module hs_wait_chan #(
  parameter int WAIT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic accept,
  output logic fire,
  output logic illegal
);
  localparam int CW = hs_mem_pkg::cnt_width(WAIT);

  generate
    if (WAIT == 0) begin : g_zero
      assign busy = 1'b0;
      assign fire = req;
    end else begin : g_wait
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (accept)        cnt <= CW'(WAIT);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
      end
      assign busy = (cnt != '0);
      assign fire = (cnt == CW'(1));
    end
  endgenerate

  assign accept  = req & ~busy;
  assign illegal = req & busy;
endmodule

// File: rtl/hs_word_array.sv
module hs_word_array #(
  parameter int AW = 4
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  hs_mem_pkg::word_t     wdata,
  input  hs_mem_pkg::word_t     wmask,
  input  logic [AW-1:0]         raddr,
  output hs_mem_pkg::word_t     rdata
);
  localparam int DEPTH = 1 << AW;

  hs_mem_pkg::word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= hs_mem_pkg::merge_bits(mem[waddr], wdata, wmask);
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hs_irq_latch.sv
module hs_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic clear,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)     irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (clear) irq <= 1'b0;
  end
endmodule

// File: rtl/hs_mem_responder.sv
module hs_mem_responder #(
  parameter int AW   = 4,
  parameter int WAIT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_busy,
  output logic [31:0]   rd_data,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [31:0]   wr_mask,
  output logic          wr_busy,
  input  logic          irq_raise,
  input  logic          irq_clear,
  output logic          irq,
  output logic          proto_err
);
  import hs_mem_pkg::*;

  localparam bit ZERO_WAIT = (WAIT == 0);

  // Named internal events, brought out for the checker.
  logic rd_accept, rd_fire, rd_illegal;
  logic wr_accept, wr_fire, wr_illegal;

  hs_wait_chan #(.WAIT(WAIT)) u_rd_chan (
    .clk(clk), .rst_n(rst_n), .req(rd_req),
    .busy(rd_busy), .accept(rd_accept), .fire(rd_fire), .illegal(rd_illegal)
  );

  hs_wait_chan #(.WAIT(WAIT)) u_wr_chan (
    .clk(clk), .rst_n(rst_n), .req(wr_req),
    .busy(wr_busy), .accept(wr_accept), .fire(wr_fire), .illegal(wr_illegal)
  );

  // Request capture: fields are held from the accepting cycle.
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  word_t         wr_data_q, wr_mask_q;

  always_ff @(posedge clk) begin
    if (rd_accept) rd_addr_q <= rd_addr;
    if (wr_accept) begin
      wr_addr_q <= wr_addr;
      wr_data_q <= wr_data;
      wr_mask_q <= wr_mask;
    end
  end

  logic [AW-1:0] rd_eff_addr, wr_eff_addr;
  word_t         wr_eff_data, wr_eff_mask, arr_rdata;

  assign rd_eff_addr = ZERO_WAIT ? rd_addr : rd_addr_q;
  assign wr_eff_addr = ZERO_WAIT ? wr_addr : wr_addr_q;
  assign wr_eff_data = ZERO_WAIT ? wr_data : wr_data_q;
  assign wr_eff_mask = ZERO_WAIT ? wr_mask : wr_mask_q;

  hs_word_array #(.AW(AW)) u_array (
    .clk(clk), .we(wr_fire), .waddr(wr_eff_addr),
    .wdata(wr_eff_data), .wmask(wr_eff_mask),
    .raddr(rd_eff_addr), .rdata(arr_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= arr_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        proto_err <= 1'b0;
    else if (rd_illegal | wr_illegal)  proto_err <= 1'b1;
  end

  hs_irq_latch u_irq (
    .clk(clk), .rst_n(rst_n), .raise(irq_raise), .clear(irq_clear), .irq(irq)
  );
endmodule

// File: rtl/hs_mem_responder_chk.sv
module hs_mem_responder_chk #(
  parameter int WAIT = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        rd_busy,
  input logic [31:0] rd_data,
  input logic        rd_fire,
  input logic        wr_req,
  input logic        wr_busy,
  input logic        irq_raise,
  input logic        irq_clear,
  input logic        irq,
  input logic        proto_err
);
  int unsigned rb_run, wb_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_run <= 0;
      wb_run <= 0;
    end else begin
      rb_run <= rd_busy ? rb_run + 1 : 0;
      wb_run <= wr_busy ? wb_run + 1 : 0;
    end
  end

  generate
    if (WAIT > 0) begin : g_wait_chk
      a_r3_rd_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_busy) |-> rb_run == WAIT);
      a_r3_wr_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_busy) |-> wb_run == WAIT);
      a_r3_rd_busy_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> rb_run < WAIT);
      a_r3_wr_busy_cap: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> wb_run < WAIT);
      a_r2_rd_start: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_busy) |=> rd_busy);
      a_r1_wr_start: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_busy) |=> wr_busy);
    end else begin : g_zero_chk
      a_r5_never_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_busy && !wr_busy);
    end
  endgenerate

  a_r7_err_on_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_req && rd_busy) || (wr_req && wr_busy)) |=> proto_err);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |=> irq);
  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clear) |=> irq);
  a_r4_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> $stable(rd_data));
endmodule

bind hs_mem_responder hs_mem_responder_chk #(.WAIT(WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_busy(rd_busy),
  .rd_data(rd_data), .rd_fire(rd_fire), .wr_req(wr_req), .wr_busy(wr_busy),
  .irq_raise(irq_raise), .irq_clear(irq_clear), .irq(irq), .proto_err(proto_err)
);

// File: tb/sim_hs_mem_responder.sv
module sim_hs_mem_responder;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, irq_raise = 1'b0, irq_clear = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0, wr_mask = '0;

  logic        b0_rd, b0_wr, irq0, err0, b1_rd, b1_wr, irq1, err1;
  logic [31:0] d0, d1;

  always #5 clk = ~clk;

  // u0: two wait states; u1: zero wait states; same stimulus.
  hs_mem_responder #(.AW(AW), .WAIT(2)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_busy(b0_rd), .rd_data(d0), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .wr_busy(b0_wr),
    .irq_raise(irq_raise), .irq_clear(irq_clear), .irq(irq0), .proto_err(err0));

  hs_mem_responder #(.AW(AW), .WAIT(0)) u1 (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_busy(b1_rd), .rd_data(d1), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .wr_busy(b1_wr),
    .irq_raise(irq_raise), .irq_clear(irq_clear), .irq(irq1), .proto_err(err1));

  int n_chk = 0, n_bad = 0;
  logic [31:0] m0 [N];
  logic [31:0] m1 [N];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] bitwise_update(logic [31:0] old_w, logic [31:0] d, logic [31:0] m);
    logic [31:0] r;
    for (int b = 0; b < 32; b++) r[b] = m[b] ? d[b] : old_w[b];
    return r;
  endfunction

  // Write at a negedge; returns at the negedge after u0 completes.
  task automatic do_write(int a, logic [31:0] d, logic [31:0] m);
    wr_req = 1'b1; wr_addr = AW'(a); wr_data = d; wr_mask = m;
    @(posedge clk); @(negedge clk);
    wr_req = 1'b0; wr_addr = ~AW'(a); wr_data = ~d; wr_mask = 32'hFFFF_FFFF; // R1 junk
    m0[a] = bitwise_update(m0[a], d, m);
    m1[a] = bitwise_update(m1[a], d, m);
    chk("R3 wr_busy u0 edge1", 32'(b0_wr), 32'd1);
    chk("R5 wr_busy u1", 32'(b1_wr), 32'd0);
    @(negedge clk);
    chk("R3 wr_busy u0 edge2", 32'(b0_wr), 32'd1);
    @(negedge clk);
    chk("R3 wr_busy u0 done", 32'(b0_wr), 32'd0);
  endtask

  task automatic do_read(int a, string tag);
    rd_req = 1'b1; rd_addr = AW'(a);
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0; rd_addr = ~AW'(a); // R2: later address ignored
    chk({tag, " R5 u1 data"}, d1, m1[a]);
    chk("R5 rd_busy u1", 32'(b1_rd), 32'd0);
    chk("R3 rd_busy u0 edge1", 32'(b0_rd), 32'd1);
    @(negedge clk);
    chk("R3 rd_busy u0 edge2", 32'(b0_rd), 32'd1);
    @(negedge clk);
    chk("R3 rd_busy u0 done", 32'(b0_rd), 32'd0);
    chk({tag, " R4 R2 u0 data"}, d0, m0[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R10 reset state
    chk("R10 reset rd_busy", 32'(b0_rd), 32'd0);
    chk("R10 reset wr_busy", 32'(b0_wr), 32'd0);
    chk("R10 reset err", 32'(err0), 32'd0);
    chk("R10 reset irq", 32'(irq0), 32'd0);
    chk("R10 reset rd_data", d0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full-mask sweep over every address (R1, R6)
    for (int a = 0; a < N; a++) begin
      m0[a] = 'x; m1[a] = 'x;
      do_write(a, (32'(a) * 32'h0101_0101) ^ 32'hDEAD_0000 ^ 32'(a << 4), 32'hFFFF_FFFF);
    end
    for (int a = 0; a < N; a++) do_read(a, "R1 full");

    // Masked sweep: inverted data, varied masks (R6)
    for (int a = 0; a < N; a++)
      do_write(a, ~m0[a], 32'hA5A5_A5A5 ^ (32'(a) * 32'h0103_0507));
    for (int a = 0; a < N; a++) do_read(a, "R6 masked");

    // Zero mask leaves word unchanged (R6)
    do_write(5, 32'h1234_5678, 32'h0);
    do_read(5, "R6 zero mask");

    // Simultaneous read and write (R11)
    rd_req = 1'b1; rd_addr = 4'd2; wr_req = 1'b1; wr_addr = 4'd9;
    wr_data = 32'hCAFE_F00D; wr_mask = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0; wr_req = 1'b0;
    m0[9] = 32'hCAFE_F00D; m1[9] = 32'hCAFE_F00D;
    chk("R11 both busy rd", 32'(b0_rd), 32'd1);
    chk("R11 both busy wr", 32'(b0_wr), 32'd1);
    chk("R11 u1 data", d1, m1[2]);
    @(negedge clk); @(negedge clk);
    chk("R11 u0 data", d0, m0[2]);
    chk("R11 no err u0", 32'(err0), 32'd0);
    chk("R11 no err u1", 32'(err1), 32'd0);
    do_read(9, "R11 write landed");

    // Illegal read while busy (R7)
    rd_req = 1'b1; rd_addr = 4'd3;
    @(posedge clk); @(negedge clk);
    rd_addr = 4'd12; // still requesting: illegal for u0, legal for u1
    @(posedge clk); @(negedge clk);
    rd_req = 1'b0;
    chk("R7 err u0", 32'(err0), 32'd1);
    chk("R7 no err u1", 32'(err1), 32'd0);
    chk("R7 u1 second read", d1, m1[12]);
    chk("R7 busy not extended", 32'(b0_rd), 32'd1);
    @(negedge clk);
    chk("R7 busy ends", 32'(b0_rd), 32'd0);
    chk("R7 u0 first read kept", d0, m0[3]);
    @(negedge clk);
    chk("R7 no restart", 32'(b0_rd), 32'd0);
    chk("R7 data unchanged", d0, m0[3]);

    // Illegal write while busy (R7)
    wr_req = 1'b1; wr_addr = 4'd4; wr_data = 32'h0BAD_BEEF; wr_mask = 32'hFFFF_FFFF;
    @(posedge clk); @(negedge clk);
    wr_addr = 4'd7; wr_data = ~m0[7];
    @(posedge clk); @(negedge clk);
    wr_req = 1'b0;
    m0[4] = 32'h0BAD_BEEF; m1[4] = 32'h0BAD_BEEF;
    m1[7] = ~m0[7];
    @(negedge clk); @(negedge clk);
    chk("R7 wr busy ends", 32'(b0_wr), 32'd0);
    do_read(4, "R7 legal write");
    do_read(7, "R7 dropped write");

    // Sticky error (R8)
    repeat (6) @(negedge clk);
    chk("R8 err sticky", 32'(err0), 32'd1);

    // Interrupt (R9)
    irq_raise = 1'b1; @(negedge clk); irq_raise = 1'b0;
    chk("R9 irq set", 32'(irq0), 32'd1);
    repeat (5) @(negedge clk);
    chk("R9 irq held", 32'(irq0), 32'd1);
    irq_clear = 1'b1; @(negedge clk); irq_clear = 1'b0;
    chk("R9 irq cleared", 32'(irq0), 32'd0);
    irq_raise = 1'b1; irq_clear = 1'b1; @(negedge clk);
    irq_raise = 1'b0; irq_clear = 1'b0;
    chk("R9 raise wins", 32'(irq0), 32'd1);
    chk("R9 raise wins u1", 32'(irq1), 32'd1);

    // Reset mid-run: flags clear, memory kept (R10)
    rd_req = 1'b1; rd_addr = 4'd1; @(negedge clk); rd_req = 1'b0;
    rst_n = 1'b0; @(negedge clk); @(negedge clk);
    chk("R10 err cleared", 32'(err0), 32'd0);
    chk("R10 irq cleared", 32'(irq0), 32'd0);
    chk("R10 busy cleared", 32'(b0_rd), 32'd0);
    chk("R10 data cleared", d0, 32'd0);
    rst_n = 1'b1; @(negedge clk);
    for (int a = 0; a < N; a++) do_read(a, "R10 memory kept");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule